// File: doc/BRIEF.md
# Serial Peripheral Byte Memory Slave

This block is the slave side of a serial peripheral interface (mode 0, most significant bit first) that sits in front of a 2048-byte store. The bus master lowers the select line and shifts in an 8-bit command. Memory commands then carry a 16-bit address, of which only the low 11 bits are used. After the address come data bytes, which stream in or out while the address counter advances. A small status byte holds six user bits and a write-enable flag. An active-low guard input can freeze the six user bits. An active-low pause input suspends a transfer between bits.

The block runs on a fast system clock. All pins pass through synchronizers, and the serial clock edges are found by comparing successive samples. No part of the logic measures time, so the serial clock may stop for any length of time. The serial output comes out as a data bit plus a separate enable, and a pad cell or the parent module builds the tri-state driver from them.

Top module: `spi_byte_mem`

## Requirements
- R1: A command byte is decoded only as the first byte after the select line falls. Bytes that follow a one-byte command (0x06 set write enable, 0x04 clear write enable) in the same select period have no effect.
- R2: While the select line is high, serial clock and data activity change nothing and the output enable stays low.
- R3: Input bits are taken on serial clock rising edges and output bits change after falling edges, most significant bit first. The first output bit appears after the falling edge that ends the last command or address bit.
- R4: Read (0x03) returns the byte at the address and then the following bytes. The address advances by one after every data byte and wraps from 0x7FF to 0x000.
- R5: Of the two address bytes, the top 5 bits are ignored, so addresses that differ only there select the same byte.
- R6: Write (0x02) stores each byte once its eighth bit is in, and only while the write-enable flag is set. Otherwise the stored byte keeps its value.
- R7: Command 0x06 sets the write-enable flag and 0x04 clears it. The flag also clears when the select line rises after a write or status-write command.
- R8: Status read (0x05) returns {user[5:0], write-enable, 0} and repeats it for every byte. Status write (0x01) loads bits [7:2] into the user bits only when the write-enable flag is set and the guard input is high. Otherwise the user bits keep their value.
- R9: While the pause input is low (sampled only while the serial clock is low), serial clock edges and select changes are ignored, the transfer state is frozen, and the output enable is low. The transfer resumes intact when the pause input is released.
- R10: The output enable is high only in the data phase of a read or a status read while selected. It is low during command and address bytes and during writes.
- R11: After reset the output enable and the output bit are 0, the write-enable flag is clear and the user status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low slave select |
| spi_clk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| pause_n_i | input | 1 | Active-low transfer pause |
| wr_guard_n_i | input | 1 | Active-low status-write guard |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Enable for the serial output driver |

## Verification
A wrong phase or a wrong bit counter shows at the ports within one byte. The output enable rises or falls at the wrong byte boundary, and read data comes back shifted or taken from the wrong address. A write-enable flag that is set when it should be clear shows up in the next status read, and so does a bad guard decision. Only a read-back of the affected byte shows a bad commit, so every write in the bench is followed by a read of the same byte, including aliased addresses and the wrap point.

// File: rtl/spi_byte_mem_pkg.sv
package spi_byte_mem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] CMD_SET_WE  = 8'h06;
    localparam logic [7:0] CMD_CLR_WE  = 8'h04;
    localparam logic [7:0] CMD_RD_STAT = 8'h05;
    localparam logic [7:0] CMD_WR_STAT = 8'h01;
    localparam logic [7:0] CMD_READ    = 8'h03;
    localparam logic [7:0] CMD_WRITE   = 8'h02;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_byte_store.sv
module spi_byte_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_byte_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              pause_n_s,
    input  logic              guard_n_s,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              miso,
    output logic              miso_oe
);
    localparam int STAT_W = 6;
    localparam int RX_W   = 16;

    typedef struct packed {
        logic              act;
        logic              paused;
        logic              clk_prev;
        phase_e            phase;
        logic [2:0]        bit_cnt;
        logic              abyte;
        logic              is_wr;
        logic              wr_pend;
        logic [RX_W-1:0]   rx_sh;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        tx_sh;
        logic              miso;
        logic              wel;
        logic [STAT_W-1:0] stat;
        logic              we;
        logic [ADDR_W-1:0] wa;
        logic [7:0]        wd;
    } eng_t;

    eng_t q, d;
    logic rise, fall;
    logic [RX_W-1:0] rx_next;
    logic [7:0] load;

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.clk_prev = sclk_s;
        rise     = sclk_s & ~q.clk_prev & q.act & ~q.paused;
        fall     = ~sclk_s & q.clk_prev & q.act & ~q.paused;
        rx_next  = {q.rx_sh[RX_W-2:0], mosi_s};
        load     = 8'h00;

        if (!q.act)       d.paused = 1'b0;
        else if (!sclk_s) d.paused = ~pause_n_s;

        if (!q.paused) begin
            if (!sel_n_s && !q.act) begin
                d.act     = 1'b1;
                d.phase   = PH_CMD;
                d.bit_cnt = 3'd0;
                d.abyte   = 1'b0;
                d.is_wr   = 1'b0;
                d.wr_pend = 1'b0;
                d.miso    = 1'b0;
            end else if (sel_n_s && q.act) begin
                d.act     = 1'b0;
                d.phase   = PH_IDLE;
                d.wr_pend = 1'b0;
                if (q.wr_pend) d.wel = 1'b0;
            end else if (rise) begin
                d.rx_sh   = rx_next;
                d.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    case (q.phase)
                        PH_CMD: begin
                            case (rx_next[7:0])
                                CMD_SET_WE: begin
                                    d.wel   = 1'b1;
                                    d.phase = PH_SKIP;
                                end
                                CMD_CLR_WE: begin
                                    d.wel   = 1'b0;
                                    d.phase = PH_SKIP;
                                end
                                CMD_RD_STAT: d.phase = PH_RSTAT;
                                CMD_WR_STAT: begin
                                    d.phase   = PH_WSTAT;
                                    d.wr_pend = 1'b1;
                                end
                                CMD_READ: begin
                                    d.phase = PH_ADDR;
                                    d.abyte = 1'b0;
                                end
                                CMD_WRITE: begin
                                    d.phase   = PH_ADDR;
                                    d.abyte   = 1'b0;
                                    d.is_wr   = 1'b1;
                                    d.wr_pend = 1'b1;
                                end
                                default: d.phase = PH_SKIP;
                            endcase
                        end
                        PH_ADDR: begin
                            if (!q.abyte) begin
                                d.abyte = 1'b1;
                            end else begin
                                d.addr  = rx_next[ADDR_W-1:0];
                                d.phase = q.is_wr ? PH_WDATA : PH_RDATA;
                            end
                        end
                        PH_WDATA: begin
                            d.we   = q.wel;
                            d.wa   = q.addr;
                            d.wd   = rx_next[7:0];
                            d.addr = q.addr + ADDR_W'(1);
                        end
                        PH_RDATA: d.addr = q.addr + ADDR_W'(1);
                        PH_WSTAT: begin
                            if (q.wel && guard_n_s) d.stat = rx_next[7:2];
                        end
                        default: ;
                    endcase
                end
            end else if (fall) begin
                if (q.bit_cnt == 3'd0) begin
                    case (q.phase)
                        PH_RDATA: load = mem_rdata;
                        PH_RSTAT: load = {q.stat, q.wel, 1'b0};
                        default:  load = 8'h00;
                    endcase
                    d.miso  = load[7];
                    d.tx_sh = {load[6:0], 1'b0};
                end else begin
                    d.miso  = q.tx_sh[7];
                    d.tx_sh = {q.tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.phase    <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_raddr = q.addr;
    assign mem_we    = q.we;
    assign mem_waddr = q.wa;
    assign mem_wdata = q.wd;
    assign miso      = q.miso;
    assign miso_oe   = q.act & ~q.paused &
                       ((q.phase == PH_RDATA) | (q.phase == PH_RSTAT));

    // R9: a paused cycle leaves the transfer state untouched
    a_r9_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        q.paused |=> ($stable(q.phase) && $stable(q.bit_cnt) &&
                      $stable(q.addr) && $stable(q.miso)));

    // R6: a store strobe only follows a cycle with the flag set
    a_r6_store_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> $past(q.wel));

    // R8: user status bits move only when enabled and unguarded
    a_r8_status_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.stat) |-> ($past(q.wel) && $past(guard_n_s)));

    // R4: inside a data phase the address only steps by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_RDATA || q.phase == PH_WDATA) &&
         ($past(q.phase) == q.phase) && (q.addr != $past(q.addr)))
        |-> (q.addr == $past(q.addr) + ADDR_W'(1)));

    // R2: while deselected, address and flag hold for the next cycle
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !q.act |=> ($stable(q.addr) && $stable(q.wel) && $stable(q.stat)));
endmodule

// File: rtl/spi_byte_mem.sv
module spi_byte_mem #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic spi_clk_i,
    input  logic mosi_i,
    input  logic pause_n_i,
    input  logic wr_guard_n_i,
    output logic miso_o,
    output logic miso_oe_o
);
    localparam int PIN_N = 5;
    localparam logic [PIN_N-1:0] PIN_RST = 5'b10011;

    logic [PIN_N-1:0] pins_raw, pins_s;
    logic [ADDR_W-1:0] raddr, waddr;
    logic [7:0] rdata, wdata;
    logic we;

    assign pins_raw = {sel_n_i, spi_clk_i, mosi_i, pause_n_i, wr_guard_n_i};

    spi_pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    spi_cmd_engine #(
        .ADDR_W(ADDR_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_s  (pins_s[4]),
        .sclk_s   (pins_s[3]),
        .mosi_s   (pins_s[2]),
        .pause_n_s(pins_s[1]),
        .guard_n_s(pins_s[0]),
        .mem_rdata(rdata),
        .mem_raddr(raddr),
        .mem_we   (we),
        .mem_waddr(waddr),
        .mem_wdata(wdata),
        .miso     (miso_o),
        .miso_oe  (miso_oe_o)
    );

    spi_byte_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(8)
    ) u_store (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(rdata)
    );
endmodule

// File: tb/spi_byte_mem_tb.sv
module spi_byte_mem_tb;
    localparam int HALF = 40;
    localparam int NVEC = 6;
    // {write address, read address, data}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 8'h5A},
        {16'h0123, 16'hF923, 8'hC3},
        {16'hF8AA, 16'h00AA, 8'h01},
        {16'h07FE, 16'h07FE, 8'hFF},
        {16'h0400, 16'h8400, 8'h80},
        {16'h0055, 16'h0055, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b0, mosi = 1'b0, pause_n = 1'b1, guard_n = 1'b1;
    logic miso, miso_oe;
    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic oe_seen;

    always #2 clk = ~clk;

    spi_byte_mem u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_i     (sel_n),
        .spi_clk_i   (sclk),
        .mosi_i      (mosi),
        .pause_n_i   (pause_n),
        .wr_guard_n_i(guard_n),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic r);
        mosi = b;
        #HALF;
        r = miso;
        sclk = 1'b1;
        #HALF;
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            #HALF;
            rx[i] = miso;
            if (i == 7) oe_seen = miso_oe;
            sclk = 1'b1;
            #HALF;
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        sel_n = 1'b0;
        #HALF;
    endtask

    task automatic desel();
        #HALF;
        sel_n = 1'b1;
        #(HALF * 2);
    endtask

    task automatic one_cmd(input logic [7:0] c);
        logic [7:0] r;
        sel();
        xfer(c, r);
        desel();
    endtask

    task automatic read_stat(output logic [7:0] s);
        logic [7:0] r;
        sel();
        xfer(8'h05, r);
        xfer(8'h00, s);
        desel();
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] r;
        sel();
        xfer(8'h02, r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        xfer(v, r);
        desel();
    endtask

    task automatic rd_byte(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] r;
        sel();
        xfer(8'h03, r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        xfer(8'h00, v);
        desel();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, s, v;
        logic b;
        #1;
        #40;
        // R11: reset state
        check("R11 oe after reset", {15'd0, miso_oe}, 16'd0);
        check("R11 out bit after reset", {15'd0, miso}, 16'd0);
        rst_n = 1'b1;
        #40;
        read_stat(s);
        check("R11 status after reset", {8'd0, s}, 16'h0000);

        // R4 R5 R6: vector table, write then aliased read
        for (int k = 0; k < NVEC; k++) begin
            one_cmd(8'h06);
            wr_byte(VEC[k][39:24], VEC[k][7:0]);
            rd_byte(VEC[k][23:8], v);
            check("R5 R6 table read-back", {8'd0, v}, {8'd0, VEC[k][7:0]});
        end

        // R6: write without flag leaves byte
        wr_byte(16'h0123, 8'h55);
        rd_byte(16'h0123, v);
        check("R6 write without flag", {8'd0, v}, 16'h00C3);

        // R1: second command in one select ignored
        sel();
        xfer(8'h06, r);
        xfer(8'h04, r);
        desel();
        read_stat(s);
        check("R1 trailing command ignored", {8'd0, s}, 16'h0002);
        // R7: clear command
        one_cmd(8'h04);
        read_stat(s);
        check("R7 clear flag", {8'd0, s}, 16'h0000);
        // R7: flag cleared by select rise after write
        one_cmd(8'h06);
        wr_byte(16'h0300, 8'h11);
        read_stat(s);
        check("R7 flag cleared after write", {8'd0, s}, 16'h0000);

        // R8: guard blocks status write
        one_cmd(8'h06);
        guard_n = 1'b0;
        sel(); xfer(8'h01, r); xfer(8'hFC, r); desel();
        guard_n = 1'b1;
        read_stat(s);
        check("R8 guarded status write", {8'd0, s}, 16'h0000);
        one_cmd(8'h06);
        sel(); xfer(8'h01, r); xfer(8'hA7, r); desel();
        read_stat(s);
        check("R8 status write applied", {8'd0, s}, 16'h00A4);
        sel(); xfer(8'h01, r); xfer(8'h10, r); desel();
        read_stat(s);
        check("R8 status write without flag", {8'd0, s}, 16'h00A4);
        // R8: status repeats across bytes
        one_cmd(8'h06);
        sel(); xfer(8'h05, r); xfer(8'h00, r); xfer(8'h00, s); desel();
        check("R8 status repeats", {8'd0, s}, 16'h00A6);
        one_cmd(8'h04);

        // R4: wrap from top address, R10 oe during write data
        one_cmd(8'h06);
        sel();
        xfer(8'h02, r);
        check("R10 oe low in command", {15'd0, oe_seen}, 16'd0);
        xfer(8'h07, r); xfer(8'hFF, r);
        xfer(8'h11, r);
        check("R10 oe low in write data", {15'd0, oe_seen}, 16'd0);
        xfer(8'h22, r);
        desel();
        sel();
        xfer(8'h03, r); xfer(8'h07, r); xfer(8'hFF, r);
        xfer(8'h00, v);
        check("R3 R4 first read byte", {8'd0, v}, 16'h0011);
        check("R10 oe high in read data", {15'd0, oe_seen}, 16'd1);
        xfer(8'h00, v);
        check("R4 wrapped read byte", {8'd0, v}, 16'h0022);
        desel();
        check("R10 oe low after deselect", {15'd0, miso_oe}, 16'd0);
        rd_byte(16'h0000, v);
        check("R4 wrap target written", {8'd0, v}, 16'h0022);

        // R2: clock activity while deselected
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
        end
        check("R2 oe low deselected", {15'd0, miso_oe}, 16'd0);
        read_stat(s);
        check("R2 state intact", {8'd0, s}, 16'h00A4);

        // R9: pause mid-byte during read
        one_cmd(8'h06);
        sel(); xfer(8'h02, r); xfer(8'h02, r); xfer(8'h00, r);
        xfer(8'h96, r); xfer(8'h3C, r); desel();
        sel();
        xfer(8'h03, r); xfer(8'h02, r); xfer(8'h00, r);
        v = 8'h00;
        for (int i = 7; i >= 5; i--) begin
            bit_io(1'b0, b);
            v[i] = b;
        end
        #HALF;
        pause_n = 1'b0;
        #(HALF * 2);
        check("R9 oe low while paused", {15'd0, miso_oe}, 16'd0);
        for (int i = 0; i < 4; i++) begin
            #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
        end
        #HALF;
        pause_n = 1'b1;
        #(HALF * 2);
        for (int i = 4; i >= 0; i--) begin
            bit_io(1'b0, b);
            v[i] = b;
        end
        check("R9 byte resumed intact", {8'd0, v}, 16'h0096);
        xfer(8'h00, v);
        check("R9 next byte after pause", {8'd0, v}, 16'h003C);
        desel();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule